// File: doc/BRIEF.md
# Card Reader Fault Status and Interrupt Register

This block collects hardware events from a two-slot smart-card reader front end and holds them in sticky status bits. A host reads the bits through an 8-bit read port, and that read clears them. Each event source is asynchronous to the host clock. It passes through a synchronizer chain and then an edge detector before it can set its bit.

While any fault or presence bit is held, an active-low interrupt line is asserted. The auxiliary event also asserts it when it is enabled. The line is also asserted while the supply alarm pulse is present. A separate output stays high while any emergency bit is set. The session control logic uses this output to keep its START bit at zero. The supervisor bit has a special clear rule: a read only clears it after the alarm pulse has ended.

Top module: `card_fault_status`

## Requirements
- R1: While reset is held, and until the first read after release (with the alarm pin high), `rd_data` is 0x10, `irq_n` is 0 and `start_clr` is 1.
- R2: The bit positions of `rd_data` are:

  | Bit | Content |
  |-----|---------|
  | 7 | always 0 |
  | 6 | protection fault, reader B |
  | 5 | protection fault, reader A |
  | 4 | supervisor |
  | 3 | presence change, reader B |
  | 2 | presence change, reader A |
  | 1 | auxiliary change |
  | 0 | overtemperature |
- R3: A change of `pres_a` or `pres_b` in either direction sets bit 2 or bit 3 respectively. The bit becomes visible after the third rising clock edge that follows the pin change.
- R4: A rising edge of (`vflt_a` OR `rflt_a`) sets bit 5. A rising edge of (`vflt_b` OR `rflt_b`) sets bit 6. A second flag rising while the first is still high sets nothing, and falling edges set nothing.
- R5: A rising edge of `overtemp` sets bit 0. Any level change of `aux_in` sets bit 1. Both follow the same three-edge latency as R3.
- R6: `irq_n` is 0 exactly while any of the following holds:
  - any of bits 6, 5, 3, 2, 0 is set
  - bit 1 is set and `aux_en` is 1
  - the synchronized alarm is high
- R7: A clock edge with `rd_stb` high clears every set bit except bit 1 and bit 4. Bit 1 is cleared only when `aux_en` is 1. No bit clears without a read.
- R8: Bit 4 is set while the synchronized alarm is high. A read during the alarm leaves it set. Once the alarm has ended, `irq_n` returns high even though bit 4 is still set. The next read then clears bit 4.
- R9: An event that sets a bit on the same edge as a clearing read leaves that bit set.
- R10: `start_clr` is 1 exactly while any of bits 6, 5, 4, 3, 2, 0 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pres_a | input | 1 | Card presence, reader A (async) |
| pres_b | input | 1 | Card presence, reader B (async) |
| vflt_a | input | 1 | Supply fault, reader A (async) |
| rflt_a | input | 1 | Reset-line fault, reader A (async) |
| vflt_b | input | 1 | Supply fault, reader B (async) |
| rflt_b | input | 1 | Reset-line fault, reader B (async) |
| alarm | input | 1 | Supply supervisor alarm pulse (async) |
| overtemp | input | 1 | Overtemperature flag (async) |
| aux_in | input | 1 | Auxiliary interrupt input (async) |
| aux_en | input | 1 | Enables the auxiliary bit in the interrupt and its clear |
| rd_stb | input | 1 | Status read strobe; clears on this edge |
| rd_data | output | 8 | Status value |
| irq_n | output | 1 | Active-low interrupt |
| start_clr | output | 1 | Holds the session START bit at zero |

## Verification
A pin change reaches its status bit after the third rising edge: two edges for the synchronizer and one for the latch. The synchronized alarm reaches `irq_n` one edge earlier, after the second edge. A read strobe takes effect on the single edge it spans. `aux_en` acts on `irq_n` combinationally. The bench therefore drives every pin on a falling edge and samples three falling edges later. It raises `rd_stb` for exactly one cycle and samples on the falling edge that follows. For the same-edge test, the strobe is placed so that it spans exactly the third edge after a pin change.

// File: rtl/card_fault_status.sv
module card_fault_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pres_a,
  input  logic       pres_b,
  input  logic       vflt_a,
  input  logic       rflt_a,
  input  logic       vflt_b,
  input  logic       rflt_b,
  input  logic       alarm,
  input  logic       overtemp,
  input  logic       aux_in,
  input  logic       aux_en,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  output logic       irq_n,
  output logic       start_clr
);
  localparam int NIN = 9;
  localparam logic [NIN-1:0] IDLE = 9'h040;
  localparam logic [6:0] STAT_RST = 7'h10;

  logic [NIN-1:0] pin_v, now_v, was_v;
  logic [NIN-1:0] sq [SYNC_STAGES];
  logic [6:0] stat, set_v, clr_v;
  logic alarm_s, flt_a_now, flt_a_was, flt_b_now, flt_b_was;

  assign pin_v = {aux_in, overtemp, alarm, rflt_b, vflt_b, rflt_a, vflt_a, pres_b, pres_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sq[i] <= IDLE;
      was_v <= IDLE;
    end else begin
      sq[0] <= pin_v;
      for (int i = 1; i < SYNC_STAGES; i++) sq[i] <= sq[i-1];
      was_v <= now_v;
    end
  end

  assign now_v     = sq[SYNC_STAGES-1];
  assign alarm_s   = now_v[6];
  assign flt_a_now = now_v[2] | now_v[3];
  assign flt_a_was = was_v[2] | was_v[3];
  assign flt_b_now = now_v[4] | now_v[5];
  assign flt_b_was = was_v[4] | was_v[5];

  assign set_v = {flt_b_now & ~flt_b_was,
                  flt_a_now & ~flt_a_was,
                  alarm_s,
                  now_v[1] ^ was_v[1],
                  now_v[0] ^ was_v[0],
                  now_v[8] ^ was_v[8],
                  now_v[7] & ~was_v[7]};

  assign clr_v = rd_stb ? {2'b11, ~alarm_s, 2'b11, aux_en, 1'b1} : 7'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= STAT_RST;
    else        stat <= (stat & ~clr_v) | set_v;
  end

  assign rd_data   = {1'b0, stat};
  assign irq_n     = ~(|{stat[6:5], stat[3:2], stat[0]} | (stat[1] & aux_en) | alarm_s);
  assign start_clr = |{stat[6:2], stat[0]};
endmodule

module card_fault_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       aux_en,
  input logic       alarm_s,
  input logic [7:0] rd_data,
  input logic       irq_n,
  input logic       start_clr
);
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n |-> (rd_data[6:5] == 2'b00 && rd_data[3:2] == 2'b00 && !rd_data[0] && !alarm_s)); // R6
  AST_SUPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[4]) |-> ($past(rd_stb) && !$past(alarm_s))); // R8
  AST_SUPL_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_s |=> rd_data[4]); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_stb) |-> (($past(rd_data) & ~rd_data) == 8'h00)); // R7
  AST_AUX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !aux_en && rd_data[1]) |=> rd_data[1]); // R7
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !start_clr |-> (rd_data[6:2] == 5'h00 && !rd_data[0])); // R10
endmodule

bind card_fault_status card_fault_status_chk chk (.*);

// File: tb/card_fault_status_test.sv
module card_fault_status_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [8:0] pins;
    logic       en;
    logic       rd;
    logic [7:0] exp;
    logic       irq;
    logic       sc;
    logic [7:0] post;
  } vec_t;

  // pins: 0 pres_a,1 pres_b,2 vflt_a,3 rflt_a,4 vflt_b,5 rflt_b,6 alarm,7 overtemp,8 aux_in
  localparam vec_t TBL [12] = '{
    '{9'h001, 1'b1, 1'b1, 8'h04, 1'b0, 1'b1, 8'h00},  // R3 rise A
    '{9'h000, 1'b1, 1'b1, 8'h04, 1'b0, 1'b1, 8'h00},  // R3 fall A
    '{9'h002, 1'b1, 1'b1, 8'h08, 1'b0, 1'b1, 8'h00},  // R3 B
    '{9'h006, 1'b1, 1'b1, 8'h20, 1'b0, 1'b1, 8'h00},  // R4 A
    '{9'h00E, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00},  // R4 second flag
    '{9'h022, 1'b1, 1'b1, 8'h40, 1'b0, 1'b1, 8'h00},  // R4 B
    '{9'h0A2, 1'b1, 1'b1, 8'h01, 1'b0, 1'b1, 8'h00},  // R5 overtemp
    '{9'h022, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00},  // R5 overtemp fall
    '{9'h122, 1'b1, 1'b1, 8'h02, 1'b0, 1'b0, 8'h00},  // R5 aux
    '{9'h022, 1'b0, 1'b1, 8'h02, 1'b1, 1'b0, 8'h02},  // R7 aux disabled
    '{9'h022, 1'b1, 1'b1, 8'h02, 1'b0, 1'b0, 8'h00},  // R6 aux enabled
    '{9'h000, 1'b1, 1'b1, 8'h08, 1'b0, 1'b1, 8'h00}   // R3 fall B
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] pins = 9'h040;
  logic aux_en = 1'b1;
  logic rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic irq_n, start_clr;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_fault_status uut (
    .clk(clk), .rst_n(rst_n),
    .pres_a(pins[0]), .pres_b(pins[1]),
    .vflt_a(pins[2]), .rflt_a(pins[3]),
    .vflt_b(pins[4]), .rflt_b(pins[5]),
    .alarm(pins[6]), .overtemp(pins[7]), .aux_in(pins[8]),
    .aux_en(aux_en), .rd_stb(rd_stb),
    .rd_data(rd_data), .irq_n(irq_n), .start_clr(start_clr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [7:0] d, input logic i, input logic s);
    chk({req, " rd_data"}, rd_data, d);
    chk({req, " irq_n"}, {7'h0, irq_n}, {7'h0, i});
    chk({req, " start_clr"}, {7'h0, start_clr}, {7'h0, s});
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 8'h10, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release", 8'h10, 1'b0, 1'b1);
    do_read();
    chk_all("R8 read during alarm", 8'h10, 1'b0, 1'b1);
    pins = 9'h000;
    settle();
    chk_all("R8 alarm ended", 8'h10, 1'b1, 1'b1);
    do_read();
    chk_all("R8 cleared after alarm", 8'h00, 1'b1, 1'b0);

    for (int k = 0; k < 12; k++) begin
      pins = TBL[k].pins;
      aux_en = TBL[k].en;
      settle();
      chk_all($sformatf("R2/R6/R10 vec %0d", k), TBL[k].exp, TBL[k].irq, TBL[k].sc);
      if (TBL[k].rd) begin
        do_read();
        chk($sformatf("R7 vec %0d after read", k), rd_data, TBL[k].post);
      end
    end

    aux_en = 1'b1;
    pins = 9'h080;
    settle();
    chk("R5 overtemp set", rd_data, 8'h01);
    pins = 9'h081;
    repeat (2) @(negedge clk);
    do_read();
    chk("R9 event wins over read", rd_data, 8'h04);
    do_read();
    chk("R7 clear after R9", rd_data, 8'h00);

    pins = 9'h0C1;
    settle();
    chk_all("R8 alarm mid-run", 8'h10, 1'b0, 1'b1);
    do_read();
    chk("R8 read in alarm keeps", rd_data, 8'h10);
    pins = 9'h081;
    settle();
    chk_all("R8 alarm over", 8'h10, 1'b1, 1'b1);
    do_read();
    chk_all("R8 final clear", 8'h00, 1'b1, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule